// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This unit sits on the data path between a memory array and its external bus. The array stores four bytes per word, each nine bits wide: eight data bits and one parity bit. Byte lane i occupies bits [9i+8:9i], and its parity bit is bit 9i+8. Three static configuration inputs select the behaviour. `cfg_ext_par` chooses between internal parity (narrow bus) and external parity (wide bus). `cfg_even` chooses even or odd parity. `cfg_flow` chooses flow-through or pipelined write timing.

In the narrow configuration the bus has no parity bits. The unit generates the ninth bit of every byte on the way into the array, keeps it off the bus on the way out, and checks every byte read back from the array. In the wide configuration the ninth bit comes from the bus and goes straight through. The unit checks the parity of each enabled write byte and leaves read data unchecked. Any failure is reported on a single active-low open-drain error line, which is modelled as a pull-down enable so that several such outputs can share one pull-up.

Both data paths are plain valid-strobed streams with no back-pressure. There is no ready signal, and a beat is taken in every cycle its strobe is high. The configuration inputs may change only while `rst_n` is low.

Top module: `bpar_unit`

## Requirements
- R1: With `cfg_even`=1 a correct byte has an even count of ones over its nine bits; with `cfg_even`=0 the count is odd. Generated parity bits follow the same rule.
- R2: With `cfg_ext_par`=0, `arr_wr_data` carries each data bit of `wr_data` unchanged, and bit 9i+8 holds the generated parity of lane i's data bits [9i+7:9i]. The incoming bit 9i+8 is ignored.
- R3: With `cfg_ext_par`=0, a read beat (`rd_valid`=1 at a rising edge) with any failing byte in `arr_rd_data` pulls the error line low in the cycle right after that edge, in both timing modes.
- R4: With `cfg_ext_par`=0, `rd_par_oe` is 0 and bit 9i+8 of `rd_data` is 0. The data bits of `rd_data` equal `arr_rd_data`.
- R5: With `cfg_ext_par`=1 and `cfg_flow`=1, a write beat with a failing enabled byte pulls the error line low in the cycle right after the beat's edge.
- R6: With `cfg_ext_par`=1 and `cfg_flow`=0, that report comes one cycle later, two cycles after the beat's edge.
- R7: With `cfg_ext_par`=1, `arr_wr_data` equals `wr_data`, `rd_data` equals `arr_rd_data`, `rd_par_oe` is 1, and read beats never raise the error line.
- R8: A write byte whose enable bit `wr_be[i]` is 0 is left out of the write check.
- R9: Each failing transfer raises the error line for exactly one cycle, however many of its bytes fail. Clean transfers never raise it.
- R10: During reset and right after it the error line is released (`err_pull_low`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_ext_par | input | 1 | 1: parity bits on the bus (write check); 0: internal parity (read check) |
| cfg_even | input | 1 | 1: even parity; 0: odd parity |
| cfg_flow | input | 1 | 1: flow-through write timing; 0: pipelined |
| wr_valid | input | 1 | Write beat strobe |
| wr_be | input | 4 | Per-byte write enable |
| wr_data | input | 36 | Write data from the bus, 9 bits per byte |
| arr_wr_data | output | 36 | Write data to the array |
| rd_valid | input | 1 | Read beat strobe |
| arr_rd_data | input | 36 | Read data from the array |
| rd_data | output | 36 | Read data to the bus |
| rd_par_oe | output | 1 | Drive enable for the bus parity bits |
| err_pull_low | output | 1 | Pull-down enable of the open-drain error line |

## Verification
The assertions check on every cycle that a failing beat is followed by the error pulse at the latency its mode demands. They also check that parity bits stay off the bus in the narrow configuration and that a clean flow-through cycle leaves the line released. Several things are shown only by the bench's scenarios: the generated parity values, the exclusion of disabled bytes, the single pulse for a transfer with several bad bytes, and pipelined clean runs, all checked against independently computed parity for both polarities and all mode combinations.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  localparam int unsigned LANE_DATA_W = 8;
  localparam int unsigned LANE_W      = LANE_DATA_W + 1;

  typedef struct packed {
    logic wr_bad;
    logic rd_bad;
  } lane_flags_t;
endpackage

// File: rtl/bpar_lane.sv
module bpar_lane
  import bpar_pkg::*;
(
  input  logic              cfg_ext_par,
  input  logic              cfg_even,
  input  logic [LANE_W-1:0] wr_byte,
  input  logic [LANE_W-1:0] rd_byte,
  output logic [LANE_W-1:0] st_byte,
  output logic [LANE_W-1:0] q_byte,
  output lane_flags_t       flags
);
  logic gen_bit;

  // Even: parity bit equals XOR of data; odd: its inverse.
  assign gen_bit = (^wr_byte[LANE_DATA_W-1:0]) ^ ~cfg_even;

  always_comb begin
    st_byte = wr_byte;
    q_byte  = rd_byte;
    if (!cfg_ext_par) begin
      st_byte[LANE_W-1] = gen_bit;
      q_byte[LANE_W-1]  = 1'b0;
    end
  end

  // A byte fails when its ones count over nine bits breaks the polarity.
  assign flags.wr_bad = (^wr_byte) ^ ~cfg_even;
  assign flags.rd_bad = (^rd_byte) ^ ~cfg_even;
endmodule

// File: rtl/bpar_err_pipe.sv
module bpar_err_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_ext_par,
  input  logic cfg_flow,
  input  logic wr_hit,
  input  logic rd_hit,
  output logic err_pull_low
);
  logic wr_s1, wr_s2, rd_s1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_s1 <= 1'b0;
      wr_s2 <= 1'b0;
      rd_s1 <= 1'b0;
    end else begin
      wr_s1 <= wr_hit & cfg_ext_par;
      wr_s2 <= wr_s1;
      rd_s1 <= rd_hit & ~cfg_ext_par;
    end
  end

  assign err_pull_low = (cfg_flow ? wr_s1 : wr_s2) | rd_s1;

  AST_RESET_RELEASED: assert property (@(posedge clk)
    !rst_n |=> !err_pull_low); // R10
endmodule

// File: rtl/bpar_unit.sv
module bpar_unit
  import bpar_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned BUS_W    = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_ext_par,
  input  logic                 cfg_even,
  input  logic                 cfg_flow,
  input  logic                 wr_valid,
  input  logic [NUM_LANES-1:0] wr_be,
  input  logic [BUS_W-1:0]     wr_data,
  output logic [BUS_W-1:0]     arr_wr_data,
  input  logic                 rd_valid,
  input  logic [BUS_W-1:0]     arr_rd_data,
  output logic [BUS_W-1:0]     rd_data,
  output logic                 rd_par_oe,
  output logic                 err_pull_low
);
  logic [NUM_LANES-1:0] wr_bad_vec, rd_bad_vec;
  logic [NUM_LANES-1:0] par_bits_out;
  logic                 wr_hit, rd_hit;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_flags_t fl;
    bpar_lane u_lane (
      .cfg_ext_par (cfg_ext_par),
      .cfg_even    (cfg_even),
      .wr_byte     (wr_data[g*LANE_W +: LANE_W]),
      .rd_byte     (arr_rd_data[g*LANE_W +: LANE_W]),
      .st_byte     (arr_wr_data[g*LANE_W +: LANE_W]),
      .q_byte      (rd_data[g*LANE_W +: LANE_W]),
      .flags       (fl)
    );
    assign wr_bad_vec[g]   = fl.wr_bad & wr_be[g];
    assign rd_bad_vec[g]   = fl.rd_bad;
    assign par_bits_out[g] = rd_data[g*LANE_W + LANE_W - 1];
  end

  assign wr_hit    = wr_valid & (|wr_bad_vec);
  assign rd_hit    = rd_valid & (|rd_bad_vec);
  assign rd_par_oe = cfg_ext_par;

  bpar_err_pipe u_err (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ext_par  (cfg_ext_par),
    .cfg_flow     (cfg_flow),
    .wr_hit       (wr_hit),
    .rd_hit       (rd_hit),
    .err_pull_low (err_pull_low)
  );

  AST_RD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ext_par && rd_valid && (|rd_bad_vec) |=> err_pull_low); // R3
  AST_PAR_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ext_par |-> (par_bits_out == '0) && !rd_par_oe); // R4
  AST_FLOW_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext_par && cfg_flow && wr_valid && (|wr_bad_vec) |=> err_pull_low); // R5
  AST_PIPE_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext_par && !cfg_flow && wr_valid && (|wr_bad_vec) |=> ##1 err_pull_low); // R6
  AST_FLOW_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext_par && cfg_flow && !(wr_valid && (|wr_bad_vec)) |=> !err_pull_low); // R9
endmodule

// File: tb/sim_bpar_unit.sv
module sim_bpar_unit;
  localparam int NL = 4;
  localparam int W  = NL * 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ext_par = 1'b0, cfg_even = 1'b1, cfg_flow = 1'b1;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [NL-1:0] wr_be = '0;
  logic [W-1:0]  wr_data = '0, arr_rd_data = '0;
  logic [W-1:0]  arr_wr_data, rd_data;
  logic rd_par_oe, err_pull_low;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic e_now = 1'b0, e_next = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  bpar_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ext_par(cfg_ext_par), .cfg_even(cfg_even),
    .cfg_flow(cfg_flow), .wr_valid(wr_valid), .wr_be(wr_be), .wr_data(wr_data),
    .arr_wr_data(arr_wr_data), .rd_valid(rd_valid), .arr_rd_data(arr_rd_data),
    .rd_data(rd_data), .rd_par_oe(rd_par_oe), .err_pull_low(err_pull_low)
  );

  function automatic logic gen_par(logic [7:0] d, logic even);
    int ones = $countones(d);
    return even ? logic'(ones % 2) : logic'((ones + 1) % 2);
  endfunction

  function automatic logic byte_bad(logic [8:0] b, logic even);
    int ones = $countones(b);
    return even ? (ones % 2 == 1) : (ones % 2 == 0);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] make_word(int err_pct);
    logic [W-1:0] w;
    for (int i = 0; i < NL; i++) begin
      logic [7:0] d = 8'($urandom);
      w[i*9 +: 9] = {gen_par(d, cfg_even), d};
      if (int'($urandom % 100) < err_pct) w[i*9 + int'($urandom % 9)] ^= 1'b1;
    end
    return w;
  endfunction

  task automatic beat(logic wv, logic [NL-1:0] be, logic [W-1:0] wd,
                      logic rv, logic [W-1:0] rd, string tag);
    logic f_wr, f_rd;
    logic [W-1:0] exp_st, exp_q;
    @(negedge clk);
    check({tag, " error line timing"}, W'(err_pull_low), W'(e_now));
    e_now = e_next;
    e_next = 1'b0;
    wr_valid = wv; wr_be = be; wr_data = wd; rd_valid = rv; arr_rd_data = rd;
    #1;
    exp_st = wd;
    exp_q  = rd;
    f_wr = 1'b0;
    f_rd = 1'b0;
    for (int i = 0; i < NL; i++) begin
      if (!cfg_ext_par) begin
        exp_st[i*9+8] = gen_par(wd[i*9 +: 8], cfg_even);
        exp_q[i*9+8]  = 1'b0;
      end
      if (be[i] && byte_bad(wd[i*9 +: 9], cfg_even)) f_wr = 1'b1;
      if (byte_bad(rd[i*9 +: 9], cfg_even)) f_rd = 1'b1;
    end
    check(cfg_ext_par ? "R7 array write data" : "R1 R2 array write data", arr_wr_data, exp_st);
    check(cfg_ext_par ? "R7 bus read data" : "R4 bus read data",
          {rd_data[W-2:0], rd_par_oe}, {exp_q[W-2:0], cfg_ext_par});
    if (cfg_ext_par) begin
      if (wv && f_wr) begin
        if (cfg_flow) e_now = 1'b1; else e_next = 1'b1;
      end
    end else if (rv && f_rd) begin
      e_now = 1'b1;
    end
  endtask

  task automatic reset_cfg(logic ext, logic even, logic flow);
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0;
    cfg_ext_par = ext; cfg_even = even; cfg_flow = flow;
    repeat (3) @(negedge clk);
    check("R10 flag released in reset", W'(err_pull_low), '0);
    rst_n = 1'b1;
    e_now = 1'b0; e_next = 1'b0;
  endtask

  task automatic flush(string tag);
    repeat (3) beat(1'b0, '0, '0, 1'b0, '0, tag);
  endtask

  initial begin
    logic [W-1:0] w;
    void'($urandom(32'd20240611));
    for (int m = 0; m < 8; m++) begin
      string tag;
      reset_cfg(logic'(m[2]), logic'(m[1]), logic'(m[0]));
      tag = m[2] ? (m[0] ? "R5 R9" : "R6 R9") : "R3 R9";
      // directed: clean beat of zeros with correct parity
      w = '0;
      for (int i = 0; i < NL; i++) w[i*9+8] = ~cfg_even;
      beat(1'b1, '1, w, 1'b1, w, tag);
      // directed: only the parity bit of lane 0 flipped
      w[8] ^= 1'b1;
      beat(1'b1, '1, w, 1'b1, w, {tag, " R1 parity-bit flip"});
      // directed: every lane bad, one pulse only
      for (int i = 1; i < NL; i++) w[i*9] ^= 1'b1;
      beat(1'b1, '1, w, 1'b1, w, {tag, " all lanes bad"});
      // directed: bad bytes only in disabled lanes
      beat(1'b1, 4'b0000, w, 1'b0, '0, "R8 disabled lanes");
      // directed: back-to-back failures
      beat(1'b1, '1, w, 1'b1, w, {tag, " back-to-back"});
      beat(1'b1, '1, w, 1'b1, w, {tag, " back-to-back"});
      flush(tag);
      for (int k = 0; k < 400; k++) begin
        logic [W-1:0] a = make_word(20);
        logic [W-1:0] b = make_word(20);
        beat(logic'($urandom % 2), NL'($urandom), a,
             logic'($urandom % 2), b, m[2] ? {tag, " R7 R8"} : tag);
      end
      flush(tag);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule